// File: doc/BRIEF.md
# GPIO Ports with Grouped Pin Interrupts

This peripheral provides several general-purpose I/O ports and one interrupt unit, all on a small 32-bit register bus with byte addresses. Each port has a data-out register, an output-enable register and a data-in view of its pads. The pads are synchronized through two flops. Software writes data-out and enable, and reads back the pad levels.

Interrupts are not raised per pin. There are eight interrupt groups. Each group is tied to one pin chosen by a 4-bit selector, and that pin's position inside its byte always equals the group number. Each group has a 3-bit trigger code that picks rising edge, falling edge, either edge, high level, low level or off. Edge events set a sticky pending flag, which software clears by writing ones to an acknowledge register. Level groups report the live synchronized level. A mask register filters the status, and one interrupt line is the OR of all masked status bits.

Top module: `gio_ctrl`

## Requirements
- R1: After reset, the trigger, selector and mask registers read 0, all pending flags are clear, every pad enable is off and `irq` is low.
- R2: Port k's data-out register (byte address 16k+4) and enable register (16k+8) read back the last value written. `pad_out` carries data-out ANDed with enable, and `pad_oe` carries the enable register. A write takes effect at the clock edge that captures it.
- R3: Port k's data-in (address 16k) returns the pad levels after a two-flop synchronizer, so a pad change is readable after the second rising clock edge that follows it.
- R4: The selector register (address 124) holds a 4-bit field for group g at bits 4g+3..4g. With field value s, group g watches pad bit 8*s+g of the flattened pad vector, which is port s/4, bit 8*(s%4)+g.
- R5: Trigger code 5 catches a rising edge, 6 a falling edge and 7 either edge. A pad change made before clock edge k sets the group's pending flag at edge k+2, and the flag stays set until it is acknowledged.
- R6: Writing address 132 clears the pending flag of every edge group whose bit is 1 and leaves the other flags alone. If an edge arrives in the same cycle as its acknowledge, the flag stays set. Address 132 reads as 0.
- R7: Trigger code 2 reports the synchronized pin level as status, and code 3 reports its inverse. The status follows the pad from clock edge k+1, and an acknowledge does not affect it.
- R8: Trigger codes 0, 1 and 4 disable a group: its status reads 0 and any pending flag is dropped.
- R9: The masked status at address 140 is the group status ANDed with the mask register (address 128, bit g for group g). `irq` is the OR of those bits.
- R10: The trigger register (address 120) holds a 3-bit field for group g at bits 3g+2..3g and reads back, as does the mask. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pad_in | input | 128 | Pad input levels, asynchronous |
| pad_out | output | 128 | Pad drive values, gated by enable |
| pad_oe | output | 128 | Pad output enables |
| irq | output | 1 | Shared interrupt request |

## Verification
Register writes show up one clock edge after they are captured. Data-in follows a pad change after two edges, a level group's status after two edges as well, since the second synchronizer flop is the one observed, and an edge group's pending flag after three. The bench drives inputs on falling edges and updates a behavioural model on each rising edge. It compares `irq`, `pad_out` and `pad_oe` with the model 1 ns after every rising edge. Register reads are taken 1 ns after the address is applied. Dedicated reads one, two and three edges after a pad change pin down the synchronizer depth and the edge-to-pending delay. An acknowledge is timed to land in the same cycle as a new edge to test the set-wins rule.

// File: rtl/gio_pkg.sv
package gio_pkg;
    localparam int NGROUP = 8;
    localparam int TRIG_W = 3;
    localparam int SEL_W  = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [TRIG_W-1:0] TRIG_HIGH = 3'd2;
    localparam logic [TRIG_W-1:0] TRIG_LOW  = 3'd3;
    localparam logic [TRIG_W-1:0] TRIG_RISE = 3'd5;
    localparam logic [TRIG_W-1:0] TRIG_FALL = 3'd6;
    localparam logic [TRIG_W-1:0] TRIG_BOTH = 3'd7;

    localparam logic [ADDR_W-1:0] OFS_TRIG = 8'd120;
    localparam logic [ADDR_W-1:0] OFS_SEL  = 8'd124;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'd128;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 8'd132;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'd140;
endpackage

// File: rtl/gio_sync.sv
module gio_sync #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
    assign prev_o = st_q.s3;
endmodule

// File: rtl/gio_src_mux.sv
module gio_src_mux
    import gio_pkg::*;
#(
    parameter int NPIN = 128
) (
    input  logic [NPIN-1:0]         now_i,
    input  logic [NPIN-1:0]         prev_i,
    input  logic [NGROUP*SEL_W-1:0] sel_i,
    output logic [NGROUP-1:0]       now_o,
    output logic [NGROUP-1:0]       prev_o
);
    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        always_comb begin
            int idx;
            idx = 8 * int'(sel_i[g*SEL_W +: SEL_W]) + g;
            if (idx < NPIN) begin
                now_o[g]  = now_i[idx];
                prev_o[g] = prev_i[idx];
            end else begin
                now_o[g]  = 1'b0;
                prev_o[g] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/gio_irq_group.sv
module gio_irq_group
    import gio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIG_W-1:0] trig_i,
    input  logic              lvl_i,
    input  logic              lvl_prev_i,
    input  logic              ack_i,
    output logic              status_o
);
    logic pend_d, pend_q;
    logic edge_mode, hit;

    always_comb begin
        edge_mode = (trig_i == TRIG_RISE) || (trig_i == TRIG_FALL) || (trig_i == TRIG_BOTH);
        unique case (trig_i)
            TRIG_RISE: hit = lvl_i & ~lvl_prev_i;
            TRIG_FALL: hit = ~lvl_i & lvl_prev_i;
            TRIG_BOTH: hit = lvl_i ^ lvl_prev_i;
            default:   hit = 1'b0;
        endcase
        pend_d = edge_mode & (hit | (pend_q & ~ack_i));
        unique case (trig_i)
            TRIG_HIGH: status_o = lvl_i;
            TRIG_LOW:  status_o = ~lvl_i;
            default:   status_o = edge_mode & pend_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    // R5: a rising edge in rising mode leaves the flag set
    p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i == TRIG_RISE && lvl_i && !lvl_prev_i) |=> pend_q);
    // R6: an acknowledge without a new event clears the flag
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ack_i && !hit) |=> !pend_q);
    // R8: outside the edge modes no flag survives
    p_off_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode) |=> !pend_q);
endmodule

// File: rtl/gio_ctrl.sv
module gio_ctrl
    import gio_pkg::*;
#(
    parameter int NPORTS      = 4,
    parameter int PORT_W      = 32,
    parameter int PORT_STRIDE = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NPORTS*PORT_W-1:0] pad_in,
    output logic [NPORTS*PORT_W-1:0] pad_out,
    output logic [NPORTS*PORT_W-1:0] pad_oe,
    output logic                     irq
);
    localparam int NPIN = NPORTS * PORT_W;

    typedef struct packed {
        logic [NPORTS-1:0][PORT_W-1:0] dout;
        logic [NPORTS-1:0][PORT_W-1:0] oe;
        logic [NGROUP*TRIG_W-1:0]      trig;
        logic [NGROUP*SEL_W-1:0]       sel;
        logic [NGROUP-1:0]             mask;
    } regs_t;

    regs_t cs_d, cs_q;
    logic [NGROUP-1:0] ack;
    logic [NPIN-1:0]   pin_now, pin_prev;
    logic [NGROUP-1:0] grp_now, grp_prev, grp_stat, masked;
    logic              wr_en;

    gio_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in),
        .sync_o(pin_now), .prev_o(pin_prev)
    );

    gio_src_mux #(.NPIN(NPIN)) u_mux (
        .now_i(pin_now), .prev_i(pin_prev), .sel_i(cs_q.sel),
        .now_o(grp_now), .prev_o(grp_prev)
    );

    for (genvar g = 0; g < NGROUP; g++) begin : g_irq
        gio_irq_group u_grp (
            .clk(clk), .rst_n(rst_n),
            .trig_i(cs_q.trig[g*TRIG_W +: TRIG_W]),
            .lvl_i(grp_now[g]), .lvl_prev_i(grp_prev[g]),
            .ack_i(ack[g]), .status_o(grp_stat[g])
        );
    end

    always_comb begin
        cs_d  = cs_q;
        ack   = '0;
        wr_en = bus_sel & bus_wr;
        if (wr_en) begin
            for (int p = 0; p < NPORTS; p++) begin
                if (bus_addr == ADDR_W'(p * PORT_STRIDE + 4)) cs_d.dout[p] = bus_wdata[PORT_W-1:0];
                if (bus_addr == ADDR_W'(p * PORT_STRIDE + 8)) cs_d.oe[p]   = bus_wdata[PORT_W-1:0];
            end
            case (bus_addr)
                OFS_TRIG: cs_d.trig = bus_wdata[NGROUP*TRIG_W-1:0];
                OFS_SEL:  cs_d.sel  = bus_wdata[NGROUP*SEL_W-1:0];
                OFS_MASK: cs_d.mask = bus_wdata[NGROUP-1:0];
                OFS_ACK:  ack       = bus_wdata[NGROUP-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign masked  = grp_stat & cs_q.mask;
    assign irq     = |masked;
    assign pad_out = cs_q.dout & cs_q.oe;
    assign pad_oe  = cs_q.oe;

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (bus_addr == ADDR_W'(p * PORT_STRIDE))     bus_rdata = DATA_W'(pin_now[p*PORT_W +: PORT_W]);
            if (bus_addr == ADDR_W'(p * PORT_STRIDE + 4)) bus_rdata = DATA_W'(cs_q.dout[p]);
            if (bus_addr == ADDR_W'(p * PORT_STRIDE + 8)) bus_rdata = DATA_W'(cs_q.oe[p]);
        end
        case (bus_addr)
            OFS_TRIG: bus_rdata = DATA_W'(cs_q.trig);
            OFS_SEL:  bus_rdata = DATA_W'(cs_q.sel);
            OFS_MASK: bus_rdata = DATA_W'(cs_q.mask);
            OFS_STAT: bus_rdata = DATA_W'(masked);
            default: ;
        endcase
    end

    // R9: clearing the whole mask silences the request line
    p_mask_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_MASK && bus_wdata[NGROUP-1:0] == '0) |=> !irq);
    // R2: a data-out write to port 0 is held for read-back
    p_dout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(4)) |=> (cs_q.dout[0] == $past(bus_wdata[PORT_W-1:0])));
endmodule

// File: tb/gio_ctrl_test.sv
module gio_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] pad_in = '0;
    logic [127:0] pad_out, pad_oe;
    logic         irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // behavioural model
    logic [31:0]  m_dout[4], m_oe[4];
    logic [31:0]  m_trig, m_sel;
    logic [7:0]   m_mask, m_pend;
    logic [127:0] h0, h1, h2;

    function automatic logic [7:0] m_status();
        logic [7:0] s;
        for (int g = 0; g < 8; g++) begin
            int code, idx;
            code = int'((m_trig >> (3*g)) & 32'h7);
            idx  = 8 * int'((m_sel >> (4*g)) & 32'hF) + g;
            if (code == 2)      s[g] = h1[idx];
            else if (code == 3) s[g] = !h1[idx];
            else if (code >= 5) s[g] = m_pend[g];
            else                s[g] = 1'b0;
        end
        return s;
    endfunction

    function automatic logic [127:0] m_pads();
        logic [127:0] v;
        for (int p = 0; p < 4; p++) v[p*32 +: 32] = m_dout[p] & m_oe[p];
        return v;
    endfunction

    function automatic logic [127:0] m_oes();
        logic [127:0] v;
        for (int p = 0; p < 4; p++) v[p*32 +: 32] = m_oe[p];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 4; p++) begin m_dout[p] = '0; m_oe[p] = '0; end
            m_trig = '0; m_sel = '0; m_mask = '0; m_pend = '0;
            h0 = '0; h1 = '0; h2 = '0;
        end else begin
            logic [7:0] ackv;
            ackv = (bus_sel && bus_wr && bus_addr == 8'd132) ? bus_wdata[7:0] : 8'h00;
            for (int g = 0; g < 8; g++) begin
                int code, idx;
                logic now, prv, ev;
                code = int'((m_trig >> (3*g)) & 32'h7);
                idx  = 8 * int'((m_sel >> (4*g)) & 32'hF) + g;
                now = h1[idx]; prv = h2[idx];
                ev = (code == 5 && now && !prv) || (code == 6 && !now && prv) || (code == 7 && now != prv);
                if (code >= 5) m_pend[g] = ev || (m_pend[g] && !ackv[g]);
                else           m_pend[g] = 1'b0;
            end
            if (bus_sel && bus_wr) begin
                for (int p = 0; p < 4; p++) begin
                    if (bus_addr == 8'(p*16 + 4)) m_dout[p] = bus_wdata;
                    if (bus_addr == 8'(p*16 + 8)) m_oe[p]   = bus_wdata;
                end
                if (bus_addr == 8'd120) m_trig = {8'h00, bus_wdata[23:0]};
                if (bus_addr == 8'd124) m_sel  = bus_wdata;
                if (bus_addr == 8'd128) m_mask = bus_wdata[7:0];
            end
            h2 = h1; h1 = h0; h0 = pad_in;
        end
        #1;
        if (rst_n && !done) begin
            chk("R2 pad_out", pad_out, m_pads());
            chk("R2 pad_oe", pad_oe, m_oes());
            chk("R9 irq", 128'(irq), 128'(|(m_status() & m_mask)));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1; v = bus_rdata; bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, 128'(v), 128'(exp));
    endtask

    task automatic stat_chk(input string tag);
        logic [31:0] v;
        rd(8'd140, v);
        chk(tag, 128'(v), 128'(m_status() & m_mask));
    endtask

    task automatic pin(input int idx, input logic val);
        @(negedge clk); pad_in[idx] = val;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 trig", 8'd120, 32'h0);
        rd_chk("R1 sel", 8'd124, 32'h0);
        rd_chk("R1 mask", 8'd128, 32'h0);
        rd_chk("R1 status", 8'd140, 32'h0);
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 irq", 128'(irq), 128'(0));
        // R10 unmapped and ack read
        rd_chk("R10 gap", 8'd12, 32'h0);
        rd_chk("R10 far", 8'd200, 32'h0);
        rd_chk("R6 ack reads 0", 8'd132, 32'h0);
        // R2 data-out and enable
        wr(8'd4, 32'hA5A5_5A5A);
        wr(8'd8, 32'hFFFF_0000);
        rd_chk("R2 dout0", 8'd4, 32'hA5A5_5A5A);
        rd_chk("R2 oe0", 8'd8, 32'hFFFF_0000);
        chk("R2 gated", 128'(pad_out[31:0]), 128'(32'hA5A5_0000));
        wr(8'd36, 32'h1234_ABCD);
        wr(8'd40, 32'h0F0F_0F0F);
        rd_chk("R2 dout2", 8'd36, 32'h1234_ABCD);
        // R3 synchronizer depth
        @(negedge clk); pad_in[63:32] = 32'h1234_5678;
        rd_chk("R3 din one edge", 8'd16, 32'h0);
        rd_chk("R3 din two edges", 8'd16, 32'h1234_5678);
        @(negedge clk); pad_in[63:32] = 32'h0;
        idle(3);
        // R4/R10 selector and trigger set-up
        wr(8'd124, 32'h0413_2F05);
        rd_chk("R4 sel readback", 8'd124, 32'h0413_2F05);
        v = (32'd5) | (32'd6 << 3) | (32'd7 << 6) | (32'd2 << 9) | (32'd3 << 12)
          | (32'd0 << 15) | (32'd4 << 18) | (32'd5 << 21);
        wr(8'd120, v);
        rd_chk("R10 trig readback", 8'd120, v);
        wr(8'd128, 32'hFF);
        rd_chk("R10 mask readback", 8'd128, 32'hFF);
        stat_chk("R7 low level active");
        // R5 rising edge timing on pin 40 (group 0, selector 5)
        pin(40, 1'b1);
        rd(8'd140, v); chk("R5 one edge", 128'(v[0]), 128'(0));
        rd(8'd140, v); chk("R5 two edges", 128'(v[0]), 128'(0));
        rd(8'd140, v); chk("R5 three edges", 128'(v[0]), 128'(1));
        // R6 ack of zero bits, then ack of bit 0
        wr(8'd132, 32'h00);
        rd(8'd140, v); chk("R6 zero ack", 128'(v[0]), 128'(1));
        wr(8'd132, 32'h01);
        rd(8'd140, v); chk("R6 ack clears", 128'(v[0]), 128'(0));
        // R5 falling on pin 1 (group 1), either edge on pin 122 (group 2)
        pin(1, 1'b1); idle(3);
        stat_chk("R5 falling ignores rise");
        pin(1, 1'b0); idle(3);
        stat_chk("R5 falling sets");
        pin(122, 1'b1); idle(3);
        stat_chk("R4 either edge port3");
        wr(8'd132, 32'h06);
        stat_chk("R6 multi ack");
        pin(122, 1'b0); idle(3);
        stat_chk("R5 either edge fall");
        // R7 level high on pin 19 (group 3), low on pin 28 (group 4)
        pin(19, 1'b1);
        rd(8'd140, v); chk("R7 level one edge", 128'(v[3]), 128'(0));
        rd(8'd140, v); chk("R7 level two edges", 128'(v[3]), 128'(1));
        pin(28, 1'b1); idle(2);
        stat_chk("R7 low level released");
        wr(8'd132, 32'h08);
        rd(8'd140, v); chk("R7 ack no effect", 128'(v[3]), 128'(1));
        pin(19, 1'b0); idle(2);
        stat_chk("R7 level follows");
        // R8 disabled groups on pins 13 and 38
        pin(13, 1'b1); pin(38, 1'b1); idle(3);
        pin(13, 1'b0); pin(38, 1'b0); idle(3);
        rd(8'd140, v); chk("R8 disabled", 128'(v[6:5]), 128'(0));
        // R6 edge and ack in the same cycle on pin 7 (group 7)
        pin(7, 1'b1);
        @(negedge clk);
        wr(8'd132, 32'h80);
        rd(8'd140, v); chk("R6 set wins", 128'(v[7]), 128'(1));
        wr(8'd132, 32'h80);
        rd(8'd140, v); chk("R6 later ack", 128'(v[7]), 128'(0));
        // R9 masking
        pin(40, 1'b0); pin(40, 1'b1); idle(3);
        wr(8'd128, 32'h01);
        stat_chk("R9 mask one");
        chk("R9 irq on", 128'(irq), 128'(1));
        wr(8'd128, 32'h00);
        stat_chk("R9 mask none");
        chk("R9 irq off", 128'(irq), 128'(0));
        // R4 selector change does not create an event
        wr(8'd128, 32'hFF);
        wr(8'd132, 32'hFF);
        wr(8'd124, 32'h0413_2F06);
        idle(3);
        rd(8'd140, v); chk("R4 no event on reselect", 128'(v[0]), 128'(0));
        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule